// File: doc/BRIEF.md
# Descriptor Ring DMA Channel Sequencer

This block is a single DMA channel that works through a circular chain of 32-byte descriptors kept in system memory. The host fills a descriptor and hands it to the engine by setting the ownership bit in its control word. The engine fetches the descriptor and copies the requested number of bytes, one word at a time, from the source address to the destination address. It then writes the control word back with the ownership bit cleared, raises an interrupt if the descriptor asked for one, and moves to the descriptor named by the next-pointer word.

When the engine reaches a descriptor it does not own, it parks in a stall state. Because it does not poll memory while parked, the host must ring the doorbell after posting new work. The engine then fetches the same descriptor again. In this way the host (the producer) and the engine (the consumer) share one ring. Clearing the enable bit stops the channel at the next safe point. After that, the host can read the halted flag and the residue of the interrupted transfer.

The engine state machine has ten states:
- HALT: idle, with halted flag set.
- CMD, CNT, SRC, DST, NXT: fetch the descriptor words.
- RD, WR: one data beat.
- WB: control-word writeback.
- STALL: waiting at an unowned descriptor for a doorbell.

Its transitions are:
- HALT→CMD when enabled.
- CMD→STALL when the ownership bit is clear; CMD→CNT when it is set; CMD→HALT when disabled.
- CNT→SRC→DST→NXT.
- NXT→RD when the count is non-zero; NXT→WB when it is zero.
- RD→WR.
- WR→RD for more words, WR→WB after the last word, WR→HALT when disabled.
- WB→CMD to follow the next pointer, or WB→HALT when disabled.
- STALL→CMD on a doorbell; STALL→HALT when disabled.

Fetch-state transitions happen only on a memory acknowledge.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset the status register reads 0x1 (halted), the residue and interrupt registers read 0, `irq_o` is 0 and `mem_req` is 0.
- R2: A descriptor is 32 bytes and 32-byte aligned. Its words are:
  - byte offset 0: control word, with the ownership bit at bit 16 and the interrupt-enable bit at bit 17;
  - offset 4: byte count;
  - offset 8: source address;
  - offset 16: destination address;
  - offset 28: next pointer.
  
  A host write to the descriptor pointer register (index 1) has its low 5 bits forced to zero.
- R3: For an owned descriptor, the engine reads one source word, then writes it to the destination, for ceil(count/4) words with both addresses rising by 4. A count of 0 moves no data.
- R4: After the last data beat the control word is written back with bit 16 cleared and the other bits unchanged. The engine then continues at the next pointer, so a ring closes on itself.
- R5: At a descriptor whose bit 16 is clear, the engine stops issuing memory requests and waits. It fetches that descriptor again only after a write of any value to the doorbell register (index 2).
- R6: When a descriptor with bit 17 set is written back, bit 0 of the interrupt register (index 5) and `irq_o` become 1. They stay 1 until the host writes 1 to that bit. A descriptor with bit 17 clear raises nothing.
- R7: Setting bit 0 of the control register (index 0) while halted starts a fetch at the descriptor pointer. Clearing it stops the engine only at one of three points: a descriptor fetch, the end of a data beat, or the stall state. The halted flag rises only after the last access is acknowledged, and no request is issued while halted.
- R8: The status register (index 3) has three flags:
  - bit 0: halted;
  - bit 1: doorbell pending, set by a doorbell write and cleared when the stall consumes it;
  - bit 2: current descriptor owned, set on fetching an owned control word and cleared on writeback.
  
  Writing 1 to bit 1 or bit 2 clears that flag.
- R9: The residue register (index 4) loads the byte count. It then drops by 4 (not below 0) on each write beat, and it holds its value while halted.
- R10: The descriptor pointer register reads the address of the current descriptor. A host write to it takes effect only while halted.
- R11: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`, and `mem_we` is never raised without `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| irq_o | output | 1 | Interrupt pending |

## Verification
Register reads are combinational and are sampled in the same cycle the index is applied. A register write becomes visible one clock later. The writeback of a control word, the interrupt flag and the halted flag are each due one clock after the acknowledge of the access that completes them. Because memory latency is variable, the bench does not count cycles. Instead it polls the memory copy of the control word, or the halted flag, under a bounded cycle limit. It then lets the pipeline settle for a fixed number of cycles and samples everything on the falling edge. Negative cases, such as an ignored pointer write, a missing doorbell or an interrupt-free descriptor, are observed through memory contents and register readback after a waiting period long enough for any wrong action to show.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

    typedef enum logic [3:0] {
        E_HALT,
        E_CMD,
        E_CNT,
        E_SRC,
        E_DST,
        E_NXT,
        E_RD,
        E_WR,
        E_WB,
        E_STALL
    } eng_state_e;

    // descriptor geometry
    localparam int unsigned DESC_BYTES = 32;
    localparam int unsigned DESC_LSB   = $clog2(DESC_BYTES);
    localparam int unsigned OFS_CTL    = 0;
    localparam int unsigned OFS_CNT    = 4;
    localparam int unsigned OFS_SRC    = 8;
    localparam int unsigned OFS_DST    = 16;
    localparam int unsigned OFS_NXT    = 28;

    // control word bits
    localparam int unsigned OWN_BIT = 16;
    localparam int unsigned IEN_BIT = 17;

    // register indices
    localparam logic [2:0] RG_CTRL  = 3'd0;
    localparam logic [2:0] RG_DPTR  = 3'd1;
    localparam logic [2:0] RG_BELL  = 3'd2;
    localparam logic [2:0] RG_STAT  = 3'd3;
    localparam logic [2:0] RG_RESID = 3'd4;
    localparam logic [2:0] RG_IRQ   = 3'd5;

    // status bits
    localparam int unsigned ST_HALT = 0;
    localparam int unsigned ST_BELL = 1;
    localparam int unsigned ST_CUR  = 2;

endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
    import ring_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              en_o,
    output logic              bell_o,
    input  logic              bell_clr_i,
    output logic              dptr_we_o,
    output logic [ADDR_W-1:0] dptr_wd_o,
    output logic              cur_clr_o,
    input  logic              irq_set_i,
    output logic              irq_o,
    input  logic              halted_i,
    input  logic              cur_valid_i,
    input  logic [DATA_W-1:0] resid_i,
    input  logic [ADDR_W-1:0] dptr_i
);

    logic en_q, bell_q, irq_q;
    logic wr_ctrl, wr_bell, wr_stat, wr_irq;

    always_comb begin
        wr_ctrl = reg_we && (reg_addr == RIDX_W'(RG_CTRL));
        wr_bell = reg_we && (reg_addr == RIDX_W'(RG_BELL));
        wr_stat = reg_we && (reg_addr == RIDX_W'(RG_STAT));
        wr_irq  = reg_we && (reg_addr == RIDX_W'(RG_IRQ));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            bell_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ctrl)
                en_q <= reg_wdata[0];
            // a fresh doorbell wins over any clear in the same cycle
            if (wr_bell)
                bell_q <= 1'b1;
            else if (bell_clr_i || (wr_stat && reg_wdata[ST_BELL]))
                bell_q <= 1'b0;
            if (irq_set_i)
                irq_q <= 1'b1;
            else if (wr_irq && reg_wdata[0])
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        dptr_we_o = reg_we && (reg_addr == RIDX_W'(RG_DPTR)) && halted_i;
        dptr_wd_o = reg_wdata[ADDR_W-1:0];
        cur_clr_o = wr_stat && reg_wdata[ST_CUR];
        en_o      = en_q;
        bell_o    = bell_q;
        irq_o     = irq_q;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RIDX_W'(RG_CTRL):  reg_rdata[0] = en_q;
            RIDX_W'(RG_DPTR):  reg_rdata = DATA_W'(dptr_i);
            RIDX_W'(RG_STAT): begin
                reg_rdata[ST_HALT] = halted_i;
                reg_rdata[ST_BELL] = bell_q;
                reg_rdata[ST_CUR]  = cur_valid_i;
            end
            RIDX_W'(RG_RESID): reg_rdata = resid_i;
            RIDX_W'(RG_IRQ):   reg_rdata[0] = irq_q;
            default:           reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
    import ring_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              bell_i,
    output logic              bell_clr_o,
    input  logic              dptr_we_i,
    input  logic [ADDR_W-1:0] dptr_wd_i,
    input  logic              cur_clr_i,
    output logic              irq_set_o,
    output logic              halted_o,
    output logic              cur_valid_o,
    output logic [DATA_W-1:0] resid_o,
    output logic [ADDR_W-1:0] dptr_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    localparam int unsigned WBYTES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-DESC_LSB){1'b1}}, {DESC_LSB{1'b0}}};

    eng_state_e st_q, st_d;

    logic [ADDR_W-1:0] cur_q, src_q, dst_q, nxt_q;
    logic [DATA_W-1:0] ctl_q, cnt_q, buf_q;
    logic              cval_q;
    logic              beat, last_beat;

    assign beat      = mem_req && mem_ack;
    assign last_beat = (cnt_q <= DATA_W'(WBYTES));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= E_HALT;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_HALT:  if (en_i) st_d = E_CMD;
            E_CMD: if (beat) begin
                if (!en_i)                  st_d = E_HALT;
                else if (!mem_rdata[OWN_BIT]) st_d = E_STALL;
                else                        st_d = E_CNT;
            end
            E_CNT:   if (beat) st_d = E_SRC;
            E_SRC:   if (beat) st_d = E_DST;
            E_DST:   if (beat) st_d = E_NXT;
            E_NXT:   if (beat) st_d = (cnt_q == '0) ? E_WB : E_RD;
            E_RD:    if (beat) st_d = E_WR;
            E_WR: if (beat) begin
                if (last_beat)  st_d = E_WB;
                else if (!en_i) st_d = E_HALT;
                else            st_d = E_RD;
            end
            E_WB:    if (beat) st_d = en_i ? E_CMD : E_HALT;
            E_STALL: begin
                if (!en_i)       st_d = E_HALT;
                else if (bell_i) st_d = E_CMD;
            end
            default: st_d = E_HALT;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            nxt_q  <= '0;
            ctl_q  <= '0;
            cnt_q  <= '0;
            buf_q  <= '0;
            cval_q <= 1'b0;
        end else begin
            if (cur_clr_i)
                cval_q <= 1'b0;
            unique case (st_q)
                E_HALT: if (dptr_we_i) cur_q <= dptr_wd_i & ALIGN_MASK;
                E_CMD: if (beat) begin
                    ctl_q <= mem_rdata;
                    if (mem_rdata[OWN_BIT] && en_i) cval_q <= 1'b1;
                end
                E_CNT: if (beat) cnt_q <= mem_rdata;
                E_SRC: if (beat) src_q <= mem_rdata[ADDR_W-1:0];
                E_DST: if (beat) dst_q <= mem_rdata[ADDR_W-1:0];
                E_NXT: if (beat) nxt_q <= mem_rdata[ADDR_W-1:0] & ALIGN_MASK;
                E_RD:  if (beat) buf_q <= mem_rdata;
                E_WR: if (beat) begin
                    cnt_q <= last_beat ? '0 : cnt_q - DATA_W'(WBYTES);
                    src_q <= src_q + ADDR_W'(WBYTES);
                    dst_q <= dst_q + ADDR_W'(WBYTES);
                end
                E_WB: if (beat) begin
                    cur_q  <= nxt_q;
                    cval_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        unique case (st_q)
            E_HALT:  mem_req = 1'b0;
            E_STALL: mem_req = 1'b0;
            E_CMD:   mem_addr = cur_q + ADDR_W'(OFS_CTL);
            E_CNT:   mem_addr = cur_q + ADDR_W'(OFS_CNT);
            E_SRC:   mem_addr = cur_q + ADDR_W'(OFS_SRC);
            E_DST:   mem_addr = cur_q + ADDR_W'(OFS_DST);
            E_NXT:   mem_addr = cur_q + ADDR_W'(OFS_NXT);
            E_RD:    mem_addr = src_q;
            E_WR: begin
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = buf_q;
            end
            E_WB: begin
                mem_we    = 1'b1;
                mem_addr  = cur_q + ADDR_W'(OFS_CTL);
                mem_wdata = ctl_q & ~(DATA_W'(1) << OWN_BIT);
            end
            default: mem_req = 1'b0;
        endcase
        bell_clr_o  = (st_q == E_STALL) && en_i && bell_i;
        irq_set_o   = (st_q == E_WB) && beat && ctl_q[IEN_BIT];
        halted_o    = (st_q == E_HALT);
        cur_valid_o = cval_q;
        resid_o     = cnt_q;
        dptr_o      = cur_q;
    end

endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
    import ring_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              irq_o
);

    logic              ctrl_en, bell, bell_clr, dptr_we, cur_clr, irq_set;
    logic              halted, cur_valid;
    logic [ADDR_W-1:0] dptr_wd, dptr;
    logic [DATA_W-1:0] resid;

    ring_dma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .en_o       (ctrl_en),
        .bell_o     (bell),
        .bell_clr_i (bell_clr),
        .dptr_we_o  (dptr_we),
        .dptr_wd_o  (dptr_wd),
        .cur_clr_o  (cur_clr),
        .irq_set_i  (irq_set),
        .irq_o      (irq_o),
        .halted_i   (halted),
        .cur_valid_i(cur_valid),
        .resid_i    (resid),
        .dptr_i     (dptr)
    );

    ring_dma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl_en),
        .bell_i     (bell),
        .bell_clr_o (bell_clr),
        .dptr_we_i  (dptr_we),
        .dptr_wd_i  (dptr_wd),
        .cur_clr_i  (cur_clr),
        .irq_set_o  (irq_set),
        .halted_o   (halted),
        .cur_valid_o(cur_valid),
        .resid_o    (resid),
        .dptr_o     (dptr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack)
    );

endmodule

// File: rtl/ring_dma_chan_chk.sv
module ring_dma_chan_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              irq_o,
    input logic              halted,
    input logic              ctrl_en
);

    assert_hold_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_write_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_quiet_when_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    assert_halt_needs_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(!ctrl_en));

    assert_irq_after_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(mem_req && mem_ack && mem_we));

endmodule

bind ring_dma_chan ring_dma_chan_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .irq_o    (irq_o),
    .halted   (halted),
    .ctrl_en  (ctrl_en)
);

// File: tb/ring_dma_chan_tb.sv
module ring_dma_chan_tb;

    localparam logic [31:0] OWN = 32'h0001_0000;
    localparam logic [31:0] IEN = 32'h0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack, irq_o;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [256];
    logic [1:0]  lat = 2'd0;
    logic [1:0]  wcnt;
    logic        hwe = 1'b0;
    logic [31:0] haddr = '0, hdata = '0;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    ring_dma_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq_o(irq_o)
    );

    assign mem_ack   = mem_req && (wcnt == lat);
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= '0;
        end else begin
            wcnt <= (mem_req && !mem_ack) ? wcnt + 2'd1 : 2'd0;
            if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else if (hwe) mem[haddr[9:2]] <= hdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic mw(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hwe = 1'b1; haddr = a; hdata = d;
        @(negedge clk);
        hwe = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] b, input logic [31:0] ctl, input logic [31:0] cnt,
                            input logic [31:0] src, input logic [31:0] dst, input logic [31:0] nxt);
        mw(b + 4, cnt); mw(b + 8, src); mw(b + 16, dst); mw(b + 28, nxt);
        mw(b, ctl);
    endtask

    task automatic wait_wb(input logic [31:0] b, input string req);
        int n = 0;
        while (mem[b[9:2]][16] !== 1'b0 && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(req, {31'd0, mem[b[9:2]][16]}, 32'd0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_rd(3'd3, d); chk("R1 stat", d, 32'h1);
        reg_rd(3'd4, d); chk("R1 resid", d, 32'h0);
        reg_rd(3'd5, d); chk("R1 irq reg", d, 32'h0);
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) mw(32'h100 + 4*i, 32'hA000_0100 + 4*i);
        put_desc(32'h00, OWN | IEN, 12, 32'h100, 32'h200, 32'h20);
        put_desc(32'h20, 32'h0, 0, 0, 0, 32'h00);
        reg_wr(3'd1, 32'h05);
        reg_rd(3'd1, d); chk("R2 dptr aligned", d, 32'h0);
        reg_wr(3'd0, 32'h1);
        wait_wb(32'h00, "R4 writeback desc0");
        for (int i = 0; i < 3; i++) chk("R3 copy word", mem[(32'h200 >> 2) + i], 32'hA000_0100 + 4*i);
        chk("R3 no overrun", mem[(32'h20C) >> 2], 32'h0);
        chk("R4 ctl writeback", mem[0], IEN);
        reg_rd(3'd5, d); chk("R6 irq set", d, 32'h1);
        chk("R6 irq_o", {31'd0, irq_o}, 32'd1);
        reg_rd(3'd1, d); chk("R4 follows next", d, 32'h20);
        reg_rd(3'd3, d); chk("R8 stat running", d, 32'h0);
        reg_rd(3'd4, d); chk("R9 resid done", d, 32'h0);
        chk("R5 no req in stall", {31'd0, mem_req}, 32'd0);
        reg_wr(3'd5, 32'h1);
        reg_rd(3'd5, d); chk("R6 irq cleared", d, 32'h0);
    endtask

    task automatic t_stall_bell;
        logic [31:0] d;
        for (int i = 0; i < 3; i++) mw(32'h140 + 4*i, 32'hB000_0140 + 4*i);
        put_desc(32'h20, OWN, 5, 32'h140, 32'h240, 32'h00);
        repeat (40) @(negedge clk);
        chk("R5 no progress without bell", mem[32'h240 >> 2], 32'h0);
        reg_wr(3'd2, 32'hDEAD);
        wait_wb(32'h20, "R5 bell resumes");
        chk("R3 round up w0", mem[32'h240 >> 2], 32'hB000_0140);
        chk("R3 round up w1", mem[32'h244 >> 2], 32'hB000_0144);
        chk("R3 round up stop", mem[32'h248 >> 2], 32'h0);
        reg_rd(3'd5, d); chk("R6 no irq without enable bit", d, 32'h0);
        reg_rd(3'd3, d); chk("R8 bell consumed", d, 32'h0);
        reg_rd(3'd1, d); chk("R4 ring wraps", d, 32'h00);
    endtask

    task automatic t_zero;
        logic [31:0] d;
        mw(32'h280, 32'h5A5A_5A5A);
        put_desc(32'h00, OWN | IEN, 0, 32'h100, 32'h280, 32'h20);
        reg_wr(3'd2, 32'h0);
        wait_wb(32'h00, "R3 zero count writeback");
        chk("R3 zero count no data", mem[32'h280 >> 2], 32'h5A5A_5A5A);
        reg_rd(3'd5, d); chk("R6 irq zero count", d, 32'h1);
        reg_wr(3'd5, 32'h1);
        reg_wr(3'd1, 32'h60);
        reg_rd(3'd1, d); chk("R10 dptr write ignored while running", d, 32'h20);
    endtask

    task automatic t_stop;
        logic [31:0] d;
        int n = 0;
        int k;
        for (int i = 0; i < 16; i++) mw(32'h300 + 4*i, 32'hC000_0300 + 4*i);
        lat = 2'd3;
        put_desc(32'h20, OWN, 64, 32'h300, 32'h380, 32'h00);
        reg_wr(3'd2, 32'h1);
        repeat (40) @(negedge clk);
        reg_wr(3'd0, 32'h0);
        d = 0;
        while (d[0] !== 1'b1 && n < 500) begin
            reg_rd(3'd3, d); n++;
        end
        chk("R7 halted after disable", {31'd0, d[0]}, 32'd1);
        chk("R8 current owned flag", {31'd0, d[2]}, 32'd1);
        chk("R4 no writeback on stop", {31'd0, mem[32'h20 >> 2][16]}, 32'd1);
        reg_rd(3'd4, d);
        chk("R9 resid partial", {31'd0, (d > 0 && d < 64 && d[1:0] == 0)}, 32'd1);
        k = (64 - int'(d)) / 4;
        chk("R9 last copied word", mem[(32'h380 >> 2) + k - 1], 32'hC000_0300 + 4*(k-1));
        chk("R9 first uncopied word", mem[(32'h380 >> 2) + k], 32'h0);
        repeat (20) @(negedge clk);
        chk("R7 bus quiet halted", {31'd0, mem_req}, 32'd0);
        reg_rd(3'd4, d);
        chk("R9 resid frozen", {31'd0, (d == 32'(64 - 4*k))}, 32'd1);
        lat = 2'd1;
    endtask

    task automatic t_w1c_restart;
        logic [31:0] d;
        reg_wr(3'd2, 32'h7);
        reg_rd(3'd3, d); chk("R8 bell flag set", d, 32'h7);
        reg_wr(3'd3, 32'h6);
        reg_rd(3'd3, d); chk("R8 w1c clears", d, 32'h1);
        put_desc(32'h40, OWN | IEN, 8, 32'h100, 32'h3C0, 32'h40);
        reg_wr(3'd1, 32'h40);
        reg_rd(3'd1, d); chk("R10 dptr accepted halted", d, 32'h40);
        reg_wr(3'd0, 32'h1);
        wait_wb(32'h40, "R7 restart at dptr");
        chk("R7 restart copy w0", mem[32'h3C0 >> 2], 32'hA000_0100);
        chk("R7 restart copy w1", mem[32'h3C4 >> 2], 32'hA000_0104);
        reg_rd(3'd5, d); chk("R6 irq restart", d, 32'h1);
        reg_rd(3'd3, d); chk("R8 owned cleared", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_basic();
                t_stall_bell();
                t_zero();
                t_stop();
                t_w1c_restart();
            end
            begin
                repeat (150000) @(posedge clk);
                nchk++; nfail++;
                $display("FAIL watchdog R1..all act=timeout exp=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule